// File: doc/BRIEF.md
# Scrambled Single-Port RAM Datapath

This block places a single-port word memory behind a scrambling datapath. Stored words are never held in plain form. On a write, the data word is XORed with a keystream and each byte is then passed through its own small substitution-permutation (S&P) network before it reaches the array. On a read, each byte goes through the inverse network and the same keystream XOR is removed. Because diffusion stays inside each byte, a byte-masked write touches only the selected bytes, and no read-modify-write cycle is needed.

The block does not contain the block cipher. In the cycle of each request it presents a 64-bit counter-mode IV, made of the data nonce followed by the logical word address, together with the current key. The keystream comes back on an input port in the same cycle. The physical row is chosen by the same kind of S&P network at address width, keyed by a separate address nonce, so the logical address space is remapped nonlinearly. Scrambling is always active. The key and both nonces reset to zero and are replaced only by a load strobe. A load takes effect for the requests that follow it, and data written under the old material then reads back as garbage.

A two-state controller (ST_IDLE, ST_RESP) sequences reads. A read request moves it to ST_RESP, or keeps it there, and in ST_RESP the read data is valid. Any cycle without a read request returns it to ST_IDLE. The depth must be a power of two whenever address rounds are non-zero. A round count of zero turns its stage into a pass-through.

Top module: `scram_ram`

## Requirements
- R1: After reset, `rvalid_o` is 0, `rdata_o` is 0, `key_o` is all zero, and the nonce field `iv_o[IV_W-1:ADDR_W]` is all zero.
- R2: While `req_i` is high, `iv_o` equals {data nonce, `addr_i`}, with the address in bits [ADDR_W-1:0], in that same cycle.
- R3: A read request (`req_i`=1, `we_i`=0) raises `rvalid_o` for exactly the following cycle. A write raises no `rvalid_o`. A word written with all bytes enabled reads back unchanged when the key, nonces and keystream are the same.
- R4: Only keystream bits [DATA_W-1:0] are used. Changing the upper keystream bits between a write and a read does not change the read data.
- R5: The keystream XOR is applied outside the byte diffusion on both paths. A read whose keystream differs by D in the low DATA_W bits from the one used by the write returns the written data XOR D.
- R6: `be_i[i]`=1 writes byte i (bits 8i+7..8i). Bytes whose mask bit is 0 keep their previous stored value. An all-zero mask changes nothing.
- R7: Address scrambling is a bijection: all DEPTH logical addresses hold independent words.
- R8: A `key_load_i` pulse updates the key, data nonce and address nonce at the next clock edge. A request in the same cycle as the load still uses the old material. Loading the original material again restores access to the old data.
- R9: After new material is loaded, words stored under the old key or old address nonce no longer read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Logical word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte write enables |
| rdata_o | output | DATA_W | Descrambled read data, 0 when not valid |
| rvalid_o | output | 1 | Read data valid |
| key_load_i | input | 1 | Load new key and nonces |
| key_i | input | KEY_W | New cipher key |
| dnonce_i | input | IV_W-ADDR_W | New data nonce |
| anonce_i | input | ADDR_W | New address nonce |
| iv_o | output | IV_W | Counter-mode IV sent to the external cipher |
| key_o | output | KEY_W | Current key sent to the external cipher |
| ks_i | input | IV_W | Keystream returned by the cipher in the same cycle |

## Verification
`iv_o` is combinational and is checked at the falling edge inside the request cycle. Read data and `rvalid_o` appear one rising edge after the read request, so the bench samples them at the next falling edge, before the controller can leave ST_RESP. Key and nonce loads become visible on `key_o` and `iv_o` one edge after the strobe. The bench therefore checks them in the following cycle, and it places a read in the load cycle itself to show that the old material still applies.

// File: rtl/scram_pkg.sv
`timescale 1ns/1ps
package scram_pkg;

    typedef enum logic {ST_IDLE, ST_RESP} scram_state_e;

    function automatic logic [3:0] sbox4(input logic [3:0] x);
        logic [3:0] y;
        unique case (x)
            4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
            4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
            4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
            4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
        endcase
        return y;
    endfunction

    function automatic logic [3:0] sbox4_inv(input logic [3:0] x);
        logic [3:0] y;
        unique case (x)
            4'h0: y = 4'h5;  4'h1: y = 4'hE;  4'h2: y = 4'hF;  4'h3: y = 4'h8;
            4'h4: y = 4'hC;  4'h5: y = 4'h1;  4'h6: y = 4'h2;  4'h7: y = 4'hD;
            4'h8: y = 4'hB;  4'h9: y = 4'h4;  4'hA: y = 4'h6;  4'hB: y = 4'h3;
            4'hC: y = 4'h0;  4'hD: y = 4'h7;  4'hE: y = 4'h9;  default: y = 4'hA;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/scram_sp_net.sv
`timescale 1ns/1ps
// Keyed substitution-permutation network of arbitrary width, forward or inverse.
module scram_sp_net #(
    parameter int W      = 8,
    parameter int ROUNDS = 2,
    parameter bit INV    = 1'b0
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] key_i,
    output logic [W-1:0] data_o
);
    import scram_pkg::*;

    localparam int NIB  = W / 4;
    localparam int HALF = W / 2;

    generate
        if (ROUNDS == 0) begin : g_bypass
            logic [W-1:0] unused_key;
            assign unused_key = key_i;
            assign data_o     = data_i;
        end else if (!INV) begin : g_fwd
            logic [W-1:0] st, fl, pm;
            always_comb begin
                st = data_i;
                fl = '0;
                pm = '0;
                for (int r = 0; r < ROUNDS; r++) begin
                    st = st ^ key_i;
                    for (int n = 0; n < NIB; n++) st[4*n +: 4] = sbox4(st[4*n +: 4]);
                    for (int i = 0; i < W; i++) fl[i] = st[W-1-i];
                    pm = fl;
                    for (int i = 0; i < HALF; i++) begin
                        pm[i]      = fl[2*i];
                        pm[i+HALF] = fl[2*i+1];
                    end
                    st = pm;
                end
                data_o = st ^ key_i;
            end
        end else begin : g_inv
            logic [W-1:0] st, up;
            always_comb begin
                st = data_i ^ key_i;
                up = '0;
                for (int r = 0; r < ROUNDS; r++) begin
                    up = st;
                    for (int i = 0; i < HALF; i++) begin
                        up[2*i]   = st[i];
                        up[2*i+1] = st[i+HALF];
                    end
                    for (int i = 0; i < W; i++) st[i] = up[W-1-i];
                    for (int n = 0; n < NIB; n++) st[4*n +: 4] = sbox4_inv(st[4*n +: 4]);
                    st = st ^ key_i;
                end
                data_o = st;
            end
        end
    endgenerate

endmodule

// File: rtl/scram_mem.sv
`timescale 1ns/1ps
// Inferred single-port array with byte enables and registered read.
module scram_mem #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int NBYTES = DATA_W / 8
) (
    input  logic              clk_i,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NBYTES-1:0] be_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (en_i) begin
            if (we_i) begin
                for (int b = 0; b < NBYTES; b++)
                    if (be_i[b]) mem[addr_i][8*b +: 8] <= wdata_i[8*b +: 8];
            end else begin
                rdata_o <= mem[addr_i];
            end
        end
    end

endmodule

// File: rtl/scram_ram.sv
`timescale 1ns/1ps
module scram_ram #(
    parameter int DEPTH       = 512,
    parameter int DATA_W      = 32,
    parameter int KEY_W       = 128,
    parameter int IV_W        = 64,
    parameter int BYTE_ROUNDS = 2,
    parameter int ADDR_ROUNDS = 2,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int NBYTES   = DATA_W / 8,
    localparam int DNONCE_W = IV_W - ADDR_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NBYTES-1:0]   be_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                rvalid_o,
    input  logic                key_load_i,
    input  logic [KEY_W-1:0]    key_i,
    input  logic [DNONCE_W-1:0] dnonce_i,
    input  logic [ADDR_W-1:0]   anonce_i,
    output logic [IV_W-1:0]     iv_o,
    output logic [KEY_W-1:0]    key_o,
    input  logic [IV_W-1:0]     ks_i
);
    import scram_pkg::*;

    scram_state_e       state_q, state_d;
    logic [KEY_W-1:0]    key_q;
    logic [DNONCE_W-1:0] dnonce_q;
    logic [ADDR_W-1:0]   anonce_q;
    logic [DATA_W-1:0]   ks_q;
    logic [DATA_W-1:0]   ks_lo;
    logic [DATA_W-1:0]   wmix, wdiff, mem_rdata, rundiff;
    logic [ADDR_W-1:0]   phys_addr;
    logic                rd_req;

    assign rd_req = req_i && !we_i;
    assign ks_lo  = ks_i[DATA_W-1:0];
    assign iv_o   = {dnonce_q, addr_i};
    assign key_o  = key_q;

    generate
        if (IV_W > DATA_W) begin : g_ks_trunc
            logic unused_ks_hi;
            assign unused_ks_hi = ^ks_i[IV_W-1:DATA_W];
        end
    endgenerate

    // Scrambling material
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            key_q    <= '0;
            dnonce_q <= '0;
            anonce_q <= '0;
        end else if (key_load_i) begin
            key_q    <= key_i;
            dnonce_q <= dnonce_i;
            anonce_q <= anonce_i;
        end
    end

    // Keystream slice held for the read response
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     ks_q <= '0;
        else if (rd_req) ks_q <= ks_lo;
    end

    // Address remap
    scram_sp_net #(.W(ADDR_W), .ROUNDS(ADDR_ROUNDS), .INV(1'b0)) u_addr_net (
        .data_i (addr_i),
        .key_i  (anonce_q),
        .data_o (phys_addr)
    );

    // Write: keystream XOR, then byte diffusion. Read: inverse diffusion.
    assign wmix = wdata_i ^ ks_lo;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        scram_sp_net #(.W(8), .ROUNDS(BYTE_ROUNDS), .INV(1'b0)) u_fwd (
            .data_i (wmix[8*b +: 8]),
            .key_i  (8'h00),
            .data_o (wdiff[8*b +: 8])
        );
        scram_sp_net #(.W(8), .ROUNDS(BYTE_ROUNDS), .INV(1'b1)) u_inv (
            .data_i (mem_rdata[8*b +: 8]),
            .key_i  (8'h00),
            .data_o (rundiff[8*b +: 8])
        );
    end

    scram_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk_i   (clk_i),
        .en_i    (req_i),
        .we_i    (we_i),
        .addr_i  (phys_addr),
        .wdata_i (wdiff),
        .be_i    (be_i),
        .rdata_o (mem_rdata)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        rvalid_o = 1'b0;
        rdata_o  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req) state_d = ST_RESP;
            end
            ST_RESP: begin
                rvalid_o = 1'b1;
                rdata_o  = rundiff ^ ks_q;
                if (!rd_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/scram_ram_chk.sv
`timescale 1ns/1ps
module scram_ram_chk #(
    parameter int DATA_W = 32,
    parameter int KEY_W  = 128,
    parameter int IV_W   = 64,
    parameter int ADDR_W = 9
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic              key_load_i,
    input logic [KEY_W-1:0]  key_i,
    input logic [IV_W-1:0]   iv_o,
    input logic [KEY_W-1:0]  key_o
);
    a_r3_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i) |=> rvalid_o);

    a_r3_no_spurious_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && !we_i) |=> !rvalid_o);

    a_r1_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rvalid_o |-> (rdata_o == '0));

    a_r2_iv_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |-> (iv_o[ADDR_W-1:0] == addr_i));

    a_r8_key_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_load_i |=> (key_o == $past(key_i)));

    a_r8_key_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !key_load_i |=> $stable(key_o));

    a_r8_nonce_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !key_load_i |=> $stable(iv_o[IV_W-1:ADDR_W]));
endmodule

bind scram_ram scram_ram_chk #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .IV_W   (IV_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .key_load_i (key_load_i),
    .key_i      (key_i),
    .iv_o       (iv_o),
    .key_o      (key_o)
);

// File: tb/scram_ram_tb.sv
`timescale 1ns/1ps
module scram_ram_tb_top;
    localparam int DEPTH = 512;
    localparam int AW    = 9;
    localparam int DW    = 32;
    localparam int KW    = 128;
    localparam int IW    = 64;
    localparam int NW    = IW - AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [3:0]    be = 4'hF;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          kload = 1'b0;
    logic [KW-1:0] kin = '0;
    logic [NW-1:0] dn_in = '0;
    logic [AW-1:0] an_in = '0;
    logic [IW-1:0] iv, ks, ks_xor = '0;
    logic [KW-1:0] key_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Behavioural stand-in for the external block cipher
    function automatic logic [IW-1:0] mix(input logic [IW-1:0] v, input logic [KW-1:0] k);
        logic [IW-1:0] t;
        t = (v ^ k[63:0]) * 64'h9E37_79B9_7F4A_7C15;
        return t ^ {t[31:0], t[63:32]} ^ k[127:64];
    endfunction

    always_comb ks = mix(iv, key_out) ^ ks_xor;

    scram_ram dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .rvalid_o(rvalid),
        .key_load_i(kload), .key_i(kin), .dnonce_i(dn_in), .anonce_i(an_in),
        .iv_o(iv), .key_o(key_out), .ks_i(ks)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] m);
        @(negedge clk);
        req = 1; we = 1; addr = a; wdata = d; be = m;
        @(negedge clk);
        req = 0; we = 0; be = 4'hF;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        @(negedge clk);
        req = 1; we = 0; addr = a;
        @(negedge clk);
        req = 0;
        d = rdata; v = rvalid;
    endtask

    task automatic load(input logic [KW-1:0] k, input logic [NW-1:0] dn, input logic [AW-1:0] an);
        @(negedge clk);
        kload = 1; kin = k; dn_in = dn; an_in = an;
        @(negedge clk);
        kload = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        addr = 9'h0A5;
        #0.5;
        chk(rvalid == 1'b0, "R1 rvalid", rvalid, 0);
        chk(rdata == '0, "R1 rdata", rdata, 0);
        chk(key_out == '0, "R1 key", key_out, 0);
        chk(iv[IW-1:AW] == '0, "R1 nonce", iv[IW-1:AW], 0);
    endtask

    task automatic t_roundtrip();
        logic [DW-1:0] d; logic v;
        logic [DW-1:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0123_4567};
        logic [AW-1:0] ads  [4] = '{9'd0, 9'd511, 9'd77, 9'd256};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req = 1; we = 1; addr = ads[i]; wdata = pats[i]; be = 4'hF;
            #0.5;
            chk(iv == {{NW{1'b0}}, ads[i]}, "R2 iv", iv, {{NW{1'b0}}, ads[i]});
            @(negedge clk);
            req = 0; we = 0;
            chk(rvalid == 1'b0, "R3 no rvalid on write", rvalid, 0);
        end
        for (int i = 0; i < 4; i++) begin
            rd(ads[i], d, v);
            chk(v == 1'b1, "R3 rvalid", v, 1);
            chk(d == pats[i], "R3 readback", d, pats[i]);
        end
        @(negedge clk);
        chk(rvalid == 1'b0, "R3 rvalid one cycle", rvalid, 0);
    endtask

    task automatic t_ks_bits();
        logic [DW-1:0] d; logic v;
        wr(9'd33, 32'hCAFE_F00D, 4'hF);
        ks_xor = 64'hA5A5_5A5A_0000_0000;
        rd(9'd33, d, v);
        chk(d == 32'hCAFE_F00D, "R4 upper keystream ignored", d, 32'hCAFE_F00D);
        ks_xor = 64'h0000_0000_1234_5678;
        rd(9'd33, d, v);
        chk(d == (32'hCAFE_F00D ^ 32'h1234_5678), "R5 keystream delta", d, 32'hCAFE_F00D ^ 32'h1234_5678);
        ks_xor = '0;
    endtask

    task automatic t_bytemask();
        logic [DW-1:0] d; logic v;
        wr(9'd100, 32'h1122_3344, 4'hF);
        wr(9'd100, 32'hAABB_CCDD, 4'b0101);
        rd(9'd100, d, v);
        chk(d == 32'h11BB_33DD, "R6 mask 0101", d, 32'h11BB_33DD);
        wr(9'd100, 32'h0000_0000, 4'b0000);
        rd(9'd100, d, v);
        chk(d == 32'h11BB_33DD, "R6 mask 0000", d, 32'h11BB_33DD);
        wr(9'd100, 32'h9900_0000, 4'b1000);
        rd(9'd100, d, v);
        chk(d == 32'h99BB_33DD, "R6 mask 1000", d, 32'h99BB_33DD);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return 32'h5A00_0000 ^ (a * 32'h0001_0003);
    endfunction

    task automatic fill_all();
        for (int a = 0; a < DEPTH; a++) wr(a[AW-1:0], pat(a), 4'hF);
    endtask

    task automatic count_bad(output int bad);
        logic [DW-1:0] d; logic v;
        bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd(a[AW-1:0], d, v);
            if (d != pat(a)) bad++;
        end
    endtask

    task automatic t_bijective();
        int bad;
        fill_all();
        count_bad(bad);
        chk(bad == 0, "R7 all addresses distinct", bad, 0);
    endtask

    task automatic t_key_change();
        logic [DW-1:0] d; logic v;
        int bad;
        logic [KW-1:0] k1 = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
        logic [NW-1:0] n1 = 55'h12_3456_789A_BCDE;
        load(k1, n1, 9'h1B3);
        fill_all();
        // load and read in the same cycle: old material applies
        @(negedge clk);
        kload = 1; kin = ~k1; dn_in = ~n1; an_in = 9'h055;
        req = 1; we = 0; addr = 9'd5;
        @(negedge clk);
        kload = 0; req = 0;
        chk(rdata == pat(5), "R8 same-cycle read uses old", rdata, pat(5));
        chk(key_out == ~k1, "R8 key updated", key_out, ~k1);
        addr = 9'd3;
        #0.5;
        chk(iv == {~n1, 9'd3}, "R8 nonce updated", iv, {~n1, 9'd3});
        count_bad(bad);
        chk(bad >= DEPTH * 3 / 4, "R9 new key garbles data", bad, DEPTH * 3 / 4);
        // only the address nonce differs from the original material
        load(k1, n1, 9'h0C4);
        count_bad(bad);
        chk(bad >= DEPTH / 2, "R9 new address nonce garbles data", bad, DEPTH / 2);
        load(k1, n1, 9'h1B3);
        count_bad(bad);
        chk(bad == 0, "R8 original material restores data", bad, 0);
        rd(9'd7, d, v);
        chk(d == pat(7) && v, "R8 spot read after restore", d, pat(7));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_roundtrip();
        t_ks_bits();
        t_bytemask();
        t_bijective();
        t_key_change();
        done = 1'b1;
        finish_run();
    end
endmodule